// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches four active-low handshake inputs from a modem or similar peripheral: clear-to-send, data-set-ready, ring indicator and carrier detect. It presents them to a processor as one 8-bit status word. The upper four bits carry the present, active-high levels of the lines. The lower four bits are sticky flags that record that a line has changed since the processor last read the word. An interrupt request stays high while any flag is set. One read strobe clears all flags.

Each external line passes through a synchroniser before any edge is looked for. A loopback input replaces the four external lines with four bits of the local modem control register: request-to-send, data-terminal-ready, and two general outputs. Change detection then runs on those looped values. Moving into or out of loopback is never reported as a change. The ring-indicator flag reports only the end of a ring, which is the pin going from low to high. The other three flags report either edge.

Top module: `modem_status_tracker`

## Requirements
- R1: With `loopback_i` low, `status_o[4]`, `[5]`, `[6]` and `[7]` are the inverses of `line_n_i[0]` (clear-to-send), `[1]` (data-set-ready), `[2]` (ring) and `[3]` (carrier) respectively, after synchronisation.
- R2: With `loopback_i` high, `status_o[7:4]` equals `mctl_i[3:0]` one clock after `mctl_i` is applied, where bit 0 is request-to-send, bit 1 is data-terminal-ready, bit 2 is general output 1 and bit 3 is general output 2. While in loopback, `line_n_i` has no effect on `status_o`.
- R3: `status_o[0]`, `[1]` and `[3]` become 1 when the clear-to-send, data-set-ready or carrier line respectively changes in either direction. Each flag stays 1 until a read.
- R4: `status_o[2]` becomes 1 only when the ring pin `line_n_i[2]` goes from 0 to 1, which is a fall of `status_o[6]`. The opposite edge leaves the flag unchanged.
- R5: A one-cycle pulse on `status_rd_i` clears `status_o[3:0]` at the next clock edge.
- R6: `irq_o` is 1 exactly when any of `status_o[3:0]` is 1.
- R7: A change whose flag update falls on the same edge as a read leaves that flag set after the read.
- R8: In loopback, a change on `mctl_i` sets the flags by the rules of R3 and R4, with general output 1 taking the ring pin's place: a 1-to-0 transition of `mctl_i[2]` sets `status_o[2]`. A switch of `loopback_i` in either direction leaves `status_o[3:0]` unchanged.
- R9: A change on `line_n_i` applied before rising edge k appears on `status_o` after edge k+2, because of two synchroniser stages and the status register. Nothing on `status_o` changes before then.
- R10: After reset, `status_o` is 0x00 and `irq_o` is 0, with all lines idle (high).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loopback_i | input | 1 | 1 selects the modem control bits as the status source |
| line_n_i | input | 4 | Active-low lines: [0] clear-to-send, [1] data-set-ready, [2] ring, [3] carrier |
| mctl_i | input | 4 | Modem control bits: [0] request-to-send, [1] data-terminal-ready, [2] general output 1, [3] general output 2 |
| status_rd_i | input | 1 | Read strobe, clears the change flags |
| status_o | output | 8 | [7:4] current line levels, [3:0] sticky change flags |
| irq_o | output | 1 | Modem status interrupt request |

## Verification
The bench builds the block with its defaults: four lines and a two-stage synchroniser. With only four lines, every ordered pair of the 16 pin patterns can be driven. This covers each combination of simultaneous edges, including the rising ring edge that must stay silent. The loopback path gets the same all-pairs sweep over the 16 control patterns. Entry to and exit from loopback are checked with flags clear. A directed case places a line change on exactly the edge of a read and checks that the change survives the read.

// File: rtl/msd_pkg.sv
package msd_pkg;
    localparam int LINES   = 4;
    localparam int IDX_CTS = 0;
    localparam int IDX_DSR = 1;
    localparam int IDX_RI  = 2;
    localparam int IDX_CD  = 3;

    // Which transitions of the active-high level set the change flag
    typedef enum logic {
        EDGE_BOTH,
        EDGE_TRAILING
    } edge_mode_e;

    typedef struct packed {
        logic loop;
    } top_state_t;

    typedef struct packed {
        logic level;
        logic flag;
    } cell_state_t;
endpackage

// File: rtl/msd_sync.sv
module msd_sync #(
    parameter int              WIDTH     = 4,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [STAGES-1:0][WIDTH-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= {STAGES{RESET_VAL}};
        end else begin
            stg_q <= stg_d;
        end
    end

    assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/msd_change_cell.sv
module msd_change_cell
    import msd_pkg::*;
#(
    parameter edge_mode_e MODE = EDGE_BOTH
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_i,
    input  logic hold_i,
    input  logic rd_i,
    output logic level_o,
    output logic flag_o
);
    cell_state_t st_d, st_q;
    logic        evt;

    always_comb begin
        if (MODE == EDGE_BOTH) begin
            evt = !hold_i && (level_i != st_q.level);
        end else begin
            evt = !hold_i && st_q.level && !level_i;
        end
        st_d.level = level_i;
        st_d.flag  = (st_q.flag && !rd_i) || evt;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign flag_o  = st_q.flag;

    // R3
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.flag && !rd_i) |=> st_q.flag);
    // R5
    read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !evt) |=> !st_q.flag);
    // R7
    read_race_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && evt) |=> st_q.flag);
endmodule

// File: rtl/modem_status_tracker.sv
module modem_status_tracker
    import msd_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             loopback_i,
    input  logic [LINES-1:0] line_n_i,
    input  logic [LINES-1:0] mctl_i,
    input  logic             status_rd_i,
    output logic [7:0]       status_o,
    output logic             irq_o
);
    top_state_t       st_d, st_q;
    logic [LINES-1:0] sync_n;
    logic [LINES-1:0] level_sel;
    logic [LINES-1:0] level_q;
    logic [LINES-1:0] flag_q;
    logic             mode_switch;

    msd_sync #(
        .WIDTH    (LINES),
        .STAGES   (SYNC_STAGES),
        .RESET_VAL({LINES{1'b1}})
    ) sync_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .din_i (line_n_i),
        .dout_o(sync_n)
    );

    always_comb begin
        st_d.loop   = loopback_i;
        mode_switch = (loopback_i != st_q.loop);
        level_sel   = loopback_i ? mctl_i : ~sync_n;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        localparam edge_mode_e MODE_G = (g == IDX_RI) ? EDGE_TRAILING : EDGE_BOTH;
        msd_change_cell #(.MODE(MODE_G)) cell_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .level_i(level_sel[g]),
            .hold_i (mode_switch),
            .rd_i   (status_rd_i),
            .level_o(level_q[g]),
            .flag_o (flag_q[g])
        );
    end

    assign status_o = {level_q, flag_q};
    assign irq_o    = |flag_q;

    // R1
    normal_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !loopback_i |=> (status_o[7:4] == ~$past(sync_n)));
    // R2
    loop_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        loopback_i |=> (status_o[7:4] == $past(mctl_i)));
    // R4
    ri_lead_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(status_o[6]) && !$past(status_o[2])) |-> !status_o[2]);
    // R4
    ri_trail_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($fell(status_o[6]) && $stable(st_q.loop)) |-> status_o[2]);
    // R8
    switch_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_switch && !status_rd_i) |=> (status_o[3:0] == $past(status_o[3:0])));
endmodule

// File: tb/modem_status_tracker_tb.sv
`timescale 1ns/1ps
module modem_status_tracker_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       loopback = 1'b0;
    logic [3:0] line_n = 4'hF;
    logic [3:0] mctl = 4'h0;
    logic       rd = 1'b0;
    logic [7:0] status;
    logic       irq;
    int         checks = 0;
    int         errors = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    modem_status_tracker dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .loopback_i (loopback),
        .line_n_i   (line_n),
        .mctl_i     (mctl),
        .status_rd_i(rd),
        .status_o   (status),
        .irq_o      (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_pulse();
        rd = 1'b1;
        wait_neg(1);
        rd = 1'b0;
    endtask

    function automatic logic [3:0] pin_flags(input logic [3:0] a, input logic [3:0] b);
        logic [3:0] f;
        f = a ^ b;
        f[2] = !a[2] && b[2];
        return f;
    endfunction

    function automatic logic [3:0] loop_flags(input logic [3:0] c, input logic [3:0] d);
        logic [3:0] f;
        f = c ^ d;
        f[2] = c[2] && !d[2];
        return f;
    endfunction

    initial begin
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
        check("R10 reset status", status, 8'h00);
        check("R10 reset irq", {7'd0, irq}, 8'h00);

        // Normal mode: all ordered pairs of pin patterns
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                logic [3:0] f;
                line_n = a[3:0];
                wait_neg(4);
                read_pulse();
                line_n = b[3:0];
                wait_neg(2);
                check("R9 no early change", status, {~a[3:0], 4'h0});
                wait_neg(1);
                f = pin_flags(a[3:0], b[3:0]);
                check("R1 R3 R4 status", status, {~b[3:0], f});
                check("R6 irq", {7'd0, irq}, {7'd0, |f});
                read_pulse();
                check("R5 read clears", status, {~b[3:0], 4'h0});
                check("R6 irq after read", {7'd0, irq}, 8'h00);
            end
        end

        // R7: change coincident with read
        line_n = 4'hF;
        wait_neg(4);
        read_pulse();
        line_n = 4'b1101;
        wait_neg(3);
        check("R3 dsr flag", status, 8'b0010_0010);
        line_n = 4'b1100;
        wait_neg(2);
        rd = 1'b1;
        wait_neg(1);
        rd = 1'b0;
        check("R7 change kept over read", status, 8'b0011_0001);
        read_pulse();

        // Enter loopback
        line_n = 4'b1010;
        mctl = 4'b0110;
        wait_neg(4);
        read_pulse();
        loopback = 1'b1;
        wait_neg(1);
        check("R8 entry no flag", status, 8'b0110_0000);
        line_n = 4'b0101;
        wait_neg(4);
        check("R2 pins ignored in loopback", status, 8'b0110_0000);

        // Loopback: all ordered pairs of control patterns
        for (int c = 0; c < 16; c++) begin
            for (int d = 0; d < 16; d++) begin
                logic [3:0] f;
                mctl = c[3:0];
                wait_neg(2);
                read_pulse();
                mctl = d[3:0];
                wait_neg(1);
                f = loop_flags(c[3:0], d[3:0]);
                check("R2 R8 loop status", status, {d[3:0], f});
                check("R6 loop irq", {7'd0, irq}, {7'd0, |f});
            end
        end

        // Leave loopback
        mctl = 4'b1001;
        wait_neg(2);
        read_pulse();
        loopback = 1'b0;
        wait_neg(1);
        check("R8 exit no flag", status, {~4'b0101, 4'h0});

        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule